// File: doc/BRIEF.md
# Serial Loopback Transceiver with Parity

This block terminates one asynchronous serial link and echoes every good character back on a second line. Characters arrive on `rx_line` as a low start bit, eight data bits with the least significant bit first, an optional parity bit, and a high stop bit. The same framing is used on `tx_line`. Bit timing comes from counting system clock cycles. The default of 5208 cycles per bit gives 9600 baud from a 50 MHz clock.

The receiver passes the line through a synchronizer and watches it for a falling edge. Half a bit period after that edge it checks the line again, so that a short glitch is not taken for a start bit. After that it samples each later bit once, at the centre of the bit. For each completed frame it raises a one-cycle strobe, together with the byte, a parity-error flag and a framing-error flag.

A byte with neither error is sent back unchanged. If the transmitter is still busy, the byte waits in a one-entry holding slot. The parity mode input chooses no parity, even parity or odd parity, and applies to both directions. The enable input stops all traffic.

Top module: `uart_echo`

## Requirements
- R1: After reset, `tx_line` is high and `rx_valid` and `overrun` are low.
- R2: A frame on `rx_line` produces a single-cycle `rx_valid` pulse, with `rx_data` holding the eight data bits. The first data bit after the start bit is bit 0.
- R3: `parity_mode` 2'b01 selects even parity: data bits plus parity bit hold an even count of ones. 2'b10 selects odd parity: that count is odd. 2'b00 and 2'b11 select no parity bit and a 10-bit frame. On receive, a parity bit that breaks the rule sets `rx_parity_err` with the strobe.
- R4: A stop bit sampled low sets `rx_frame_err` with the strobe.
- R5: A low pulse on `rx_line` shorter than half a bit period produces no strobe, and the receiver then accepts the next frame.
- R6: Every byte received without error is sent on `tx_line` in the same frame format. The transmitted parity bit is generated according to the current `parity_mode`.
- R7: A byte received with a parity or framing error is not transmitted.
- R8: A good byte that arrives while the transmitter is busy waits in a one-entry slot. If the slot is already full, the new byte is dropped and `overrun` pulses for one cycle. Bytes that are kept leave in the order they arrived.
- R9: While `enable` is low, no frame is received, `tx_line` stays high, and the holding slot is emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Allows receive and transmit activity when high |
| parity_mode | input | 2 | 00/11 no parity, 01 even, 10 odd |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tx_line | output | 1 | Serial echo output, idle high |
| rx_valid | output | 1 | One-cycle strobe when a frame has been received |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Parity mismatch on the last received frame |
| rx_frame_err | output | 1 | Stop bit was low on the last received frame |
| overrun | output | 1 | One-cycle pulse when a good byte is dropped |

## Verification
The assertions check, on every cycle, the rules that hold between registers:
- the receive strobe never lasts two cycles;
- an idle transmitter holds the line high;
- every transmit frame opens with a low start bit;
- a disabled block goes quiet on the next cycle;
- an overrun leaves the holding slot full;
- an errored byte does not start a transmission.

Other properties depend on the contents of whole frames, and only the bench scenarios can show them:
- bit order and parity values;
- glitch rejection;
- the order of echoed bytes and which byte is dropped under sustained overload.

The bench decodes every transmitted frame and compares it with queues of expected bytes.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

   typedef enum logic [1:0] {
      PMODE_NONE = 2'b00,
      PMODE_EVEN = 2'b01,
      PMODE_ODD  = 2'b10,
      PMODE_OFF  = 2'b11
   } par_mode_t;

   // true when the frame carries a parity bit
   function automatic logic par_enabled(input par_mode_t m);
      return (m == PMODE_EVEN) || (m == PMODE_ODD);
   endfunction

   // parity bit value from the xor-reduction of the data bits
   function automatic logic par_bit(input par_mode_t m, input logic data_xor);
      return (m == PMODE_ODD) ? ~data_xor : data_xor;
   endfunction

endpackage

// File: rtl/uart_echo_sync.sv
module uart_echo_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   initial begin
      stages_range_chk: assert (STAGES >= 2) else $error("sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
   import uart_echo_pkg::*;
#(
   parameter int CLKS_PER_BIT = 5208,
   parameter int DATA_BITS    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 rx_s,
   input  logic [1:0]           mode,
   output logic                 valid,
   output logic [DATA_BITS-1:0] data,
   output logic                 perr,
   output logic                 ferr
);

   localparam int CW = $clog2(CLKS_PER_BIT);
   localparam int IW = $clog2(DATA_BITS);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_t;

   rx_state_t             state;
   logic [CW-1:0]         cnt;
   logic [IW-1:0]         idx;
   logic [DATA_BITS-1:0]  shreg;
   logic                  prev;
   logic                  pbit;
   par_mode_t             mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= R_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         prev   <= 1'b1;
         pbit   <= 1'b0;
         mode_q <= PMODE_NONE;
         valid  <= 1'b0;
         data   <= '0;
         perr   <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         valid <= 1'b0;
         prev  <= rx_s;
         if (!enable) begin
            state <= R_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               R_IDLE: begin
                  if (prev && !rx_s) begin
                     state  <= R_START;
                     cnt    <= '0;
                     mode_q <= par_mode_t'(mode);
                  end
               end
               R_START: begin
                  if (cnt == HALF) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= rx_s ? R_IDLE : R_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               R_DATA: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                     if (idx == IW'(DATA_BITS - 1))
                        state <= par_enabled(mode_q) ? R_PAR : R_STOP;
                     else
                        idx <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               R_PAR: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     pbit  <= rx_s;
                     state <= R_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               R_STOP: begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     valid <= 1'b1;
                     data  <= shreg;
                     ferr  <= !rx_s;
                     perr  <= par_enabled(mode_q) && (pbit != par_bit(mode_q, ^shreg));
                     state <= R_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= R_IDLE;
            endcase
         end
      end
   end

   // R2
   rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid) else $error("receive strobe lasted more than one cycle");

endmodule

// File: rtl/uart_echo_tx.sv
module uart_echo_tx
   import uart_echo_pkg::*;
#(
   parameter int CLKS_PER_BIT = 5208,
   parameter int DATA_BITS    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] data,
   input  logic [1:0]           mode,
   output logic                 busy,
   output logic                 line
);

   localparam int SW = DATA_BITS + 2;
   localparam int CW = $clog2(CLKS_PER_BIT);
   localparam int LW = $clog2(DATA_BITS + 3);
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

   logic [SW-1:0] shreg;
   logic [CW-1:0] cnt;
   logic [LW-1:0] left;
   par_mode_t     m;

   assign m = par_mode_t'(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         line  <= 1'b1;
         cnt   <= '0;
         left  <= '0;
         shreg <= '1;
      end else if (!enable) begin
         busy <= 1'b0;
         line <= 1'b1;
         cnt  <= '0;
      end else if (!busy) begin
         if (load) begin
            busy <= 1'b1;
            line <= 1'b0;
            cnt  <= '0;
            if (par_enabled(m)) begin
               shreg <= {1'b1, par_bit(m, ^data), data};
               left  <= LW'(DATA_BITS + 2);
            end else begin
               shreg <= {2'b11, data};
               left  <= LW'(DATA_BITS + 1);
            end
         end
      end else if (cnt == LAST) begin
         cnt <= '0;
         if (left == '0) begin
            busy <= 1'b0;
            line <= 1'b1;
         end else begin
            line  <= shreg[0];
            shreg <= {1'b1, shreg[SW-1:1]};
            left  <= left - 1'b1;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1
   tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> line) else $error("idle transmitter drove the line low");

   // R6
   tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !line) else $error("frame did not open with a low start bit");

endmodule

// File: rtl/uart_echo.sv
module uart_echo #(
   parameter int CLKS_PER_BIT = 5208,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [1:0]           parity_mode,
   input  logic                 rx_line,
   output logic                 tx_line,
   output logic                 rx_valid,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_parity_err,
   output logic                 rx_frame_err,
   output logic                 overrun
);

   initial begin
      clks_range_chk: assert (CLKS_PER_BIT >= 8) else $error("bit period too short");
      width_range_chk: assert (DATA_BITS >= 5 && DATA_BITS <= 9) else $error("unsupported data width");
   end

   logic                 rx_s;
   logic                 tx_busy;
   logic                 tx_load;
   logic                 good;
   logic                 hold_valid;
   logic [DATA_BITS-1:0] hold_data;
   logic [DATA_BITS-1:0] tx_data;

   uart_echo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
   );

   uart_echo_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) i_rx (
      .clk(clk), .rst_n(rst_n), .enable(enable), .rx_s(rx_s), .mode(parity_mode),
      .valid(rx_valid), .data(rx_data), .perr(rx_parity_err), .ferr(rx_frame_err)
   );

   assign good    = rx_valid && !rx_parity_err && !rx_frame_err;
   assign tx_load = !tx_busy && (hold_valid || good);
   assign tx_data = hold_valid ? hold_data : rx_data;

   uart_echo_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) i_tx (
      .clk(clk), .rst_n(rst_n), .enable(enable), .load(tx_load), .data(tx_data),
      .mode(parity_mode), .busy(tx_busy), .line(tx_line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_data  <= '0;
         overrun    <= 1'b0;
      end else begin
         overrun <= 1'b0;
         if (!enable) begin
            hold_valid <= 1'b0;
         end else if (good) begin
            if (tx_load && hold_valid) begin
               hold_data <= rx_data;
            end else if (!tx_load) begin
               if (!hold_valid) begin
                  hold_valid <= 1'b1;
                  hold_data  <= rx_data;
               end else begin
                  overrun <= 1'b1;
               end
            end
         end else if (tx_load) begin
            hold_valid <= 1'b0;
         end
      end
   end

   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (tx_line && !rx_valid)) else $error("activity while disabled");

   // R8
   overrun_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> hold_valid) else $error("overrun with an empty holding slot");

   // R7
   no_echo_of_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (rx_parity_err || rx_frame_err) && !hold_valid && !tx_busy && enable)
      |=> !tx_busy) else $error("errored byte started a transmission");

endmodule

// File: tb/test_uart_echo.sv
module test_uart_echo;

   localparam int CLK_PERIOD = 10;
   localparam int CPB        = 16;

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       fe;
   } rx_ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] pmode = 2'b00;
   logic       rx_line = 1'b1;
   logic       tx_line;
   logic       rx_valid;
   logic [7:0] rx_data;
   logic       rx_parity_err;
   logic       rx_frame_err;
   logic       overrun;

   int checks = 0;
   int errors = 0;
   int ovr_count = 0;
   bit ovr_allowed = 1'b0;
   bit done = 1'b0;
   logic en_at_edge = 1'b0;

   rx_ev_t     rx_got[$];
   rx_ev_t     rx_exp[$];
   logic [7:0] tx_got[$];
   logic [7:0] tx_exp[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_echo #(.CLKS_PER_BIT(CPB), .DATA_BITS(8), .SYNC_STAGES(2)) i_uart_echo (
      .clk(clk), .rst_n(rst_n), .enable(enable), .parity_mode(pmode),
      .rx_line(rx_line), .tx_line(tx_line), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .overrun(overrun)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit par_on(input logic [1:0] m);
      return m == 2'b01 || m == 2'b10;
   endfunction

   function automatic logic exp_par(input logic [1:0] m, input logic [7:0] d);
      int ones = 0;
      for (int i = 0; i < 8; i++) ones += d[i];
      return (m == 2'b01) ? logic'(ones % 2) : logic'((ones + 1) % 2);
   endfunction

   // per-clock reference: disabled means quiet, overrun only where the scenario allows it
   always @(posedge clk) en_at_edge <= enable;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!en_at_edge) begin
            check(tx_line === 1'b1 && rx_valid === 1'b0, "R9 quiet while disabled",
                  {tx_line, rx_valid}, 2'b10);
         end
         if (!ovr_allowed) check(overrun === 1'b0, "R8 no spurious overrun", overrun, 0);
         if (rx_valid) rx_got.push_back({rx_data, rx_parity_err, rx_frame_err});
         if (overrun) ovr_count++;
      end
   end

   // transmit-side decoder
   initial begin
      logic tx_prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && tx_prev && !tx_line) begin
            logic [7:0] b;
            logic       p;
            repeat (CPB/2) @(negedge clk);
            check(tx_line == 1'b0, "R6 start bit", tx_line, 0);
            for (int i = 0; i < 8; i++) begin
               repeat (CPB) @(negedge clk);
               b[i] = tx_line;
            end
            if (par_on(pmode)) begin
               repeat (CPB) @(negedge clk);
               p = tx_line;
               check(p == exp_par(pmode, b), "R6 R3 transmitted parity", p, exp_par(pmode, b));
            end
            repeat (CPB) @(negedge clk);
            check(tx_line == 1'b1, "R6 stop bit", tx_line, 1);
            tx_got.push_back(b);
            tx_prev = 1'b1;
         end else begin
            tx_prev = tx_line;
         end
      end
   end

   task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit bad_stop,
                             input int stop_len);
      logic pb;
      bit   pe;
      rx_line = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = d[i];
         repeat (CPB) @(negedge clk);
      end
      pe = 1'b0;
      if (par_on(pmode)) begin
         pb = exp_par(pmode, d) ^ flip_par;
         pe = flip_par;
         rx_line = pb;
         repeat (CPB) @(negedge clk);
      end
      rx_line = !bad_stop;
      repeat (stop_len) @(negedge clk);
      if (bad_stop) begin
         rx_line = 1'b1;
         repeat (CPB) @(negedge clk);
      end
      rx_exp.push_back({d, logic'(pe), logic'(bad_stop)});
      if (!pe && !bad_stop) tx_exp.push_back(d);
   endtask

   task automatic settle_and_compare(input string rx_req, input string tx_req);
      repeat (14 * CPB) @(negedge clk);
      check(rx_got.size() == rx_exp.size(), rx_req, rx_got.size(), rx_exp.size());
      for (int i = 0; i < rx_exp.size() && i < rx_got.size(); i++)
         check(rx_got[i] == rx_exp[i], rx_req, rx_got[i], rx_exp[i]);
      check(tx_got.size() == tx_exp.size(), tx_req, tx_got.size(), tx_exp.size());
      for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
         check(tx_got[i] == tx_exp[i], tx_req, tx_got[i], tx_exp[i]);
      rx_got.delete(); rx_exp.delete(); tx_got.delete(); tx_exp.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] sent[$];
      int j;
      bit subseq;

      repeat (5) @(negedge clk);
      // R1 reset state
      check(tx_line == 1'b1, "R1 tx_line after reset", tx_line, 1);
      check(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
      check(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      enable = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R6 no parity, several patterns
      pmode = 2'b00;
      send_frame(8'hA5, 0, 0, CPB);
      send_frame(8'h3C, 0, 0, CPB);
      send_frame(8'h00, 0, 0, CPB);
      send_frame(8'hFF, 0, 0, CPB);
      settle_and_compare("R2 receive no parity", "R6 echo no parity");

      // R3 even parity
      pmode = 2'b01;
      send_frame(8'h31, 0, 0, CPB);
      send_frame(8'h0F, 0, 0, CPB);
      settle_and_compare("R3 receive even", "R6 echo even");

      // R3 odd parity
      pmode = 2'b10;
      send_frame(8'h80, 0, 0, CPB);
      send_frame(8'h7E, 0, 0, CPB);
      settle_and_compare("R3 receive odd", "R6 echo odd");

      // R3 mode 11 acts as no parity
      pmode = 2'b11;
      send_frame(8'h96, 0, 0, CPB);
      settle_and_compare("R3 receive mode 11", "R6 echo mode 11");

      // R3 R7 bad parity flagged, not echoed
      pmode = 2'b01;
      send_frame(8'h55, 1, 0, CPB);
      send_frame(8'h12, 0, 0, CPB);
      settle_and_compare("R3 parity error flag", "R7 bad parity not echoed");

      // R4 R7 bad stop flagged, not echoed
      pmode = 2'b00;
      send_frame(8'hC3, 0, 1, CPB);
      send_frame(8'h44, 0, 0, CPB);
      settle_and_compare("R4 frame error flag", "R7 bad stop not echoed");

      // R5 glitch rejected, next frame accepted
      rx_line = 1'b0;
      repeat (CPB/4) @(negedge clk);
      rx_line = 1'b1;
      repeat (2 * CPB) @(negedge clk);
      check(rx_got.size() == 0, "R5 glitch gives no strobe", rx_got.size(), 0);
      send_frame(8'h69, 0, 0, CPB);
      settle_and_compare("R5 receive after glitch", "R5 echo after glitch");

      // R9 disabled: frame ignored
      enable = 1'b0;
      repeat (2) @(negedge clk);
      send_frame(8'h5A, 0, 0, CPB);
      rx_exp.delete(); tx_exp.delete();
      repeat (2 * CPB) @(negedge clk);
      enable = 1'b1;
      settle_and_compare("R9 no receive while disabled", "R9 no echo while disabled");
      send_frame(8'hE1, 0, 0, CPB);
      settle_and_compare("R9 receive after re-enable", "R9 echo after re-enable");

      // R8 sustained overload with short stop bits
      ovr_allowed = 1'b1;
      ovr_count = 0;
      for (int k = 0; k < 60; k++) begin
         logic [7:0] v;
         v = 8'(k * 7 + 3);
         sent.push_back(v);
         send_frame(v, 0, 0, CPB/2 + 4);
      end
      repeat (40 * CPB) @(negedge clk);
      check(rx_got.size() == 60, "R2 strobes under load", rx_got.size(), 60);
      check(ovr_count >= 1, "R8 overrun reported", ovr_count, 1);
      check(tx_got.size() + ovr_count == 60, "R8 kept plus dropped", tx_got.size() + ovr_count, 60);
      if (tx_got.size() >= 2) begin
         check(tx_got[0] == sent[0], "R8 first byte kept", tx_got[0], sent[0]);
         check(tx_got[1] == sent[1], "R8 second byte kept", tx_got[1], sent[1]);
      end
      j = 0;
      subseq = 1'b1;
      foreach (tx_got[i]) begin
         while (j < sent.size() && sent[j] != tx_got[i]) j++;
         if (j >= sent.size()) subseq = 1'b0;
         else j++;
      end
      check(subseq, "R8 kept bytes in arrival order", subseq, 1);
      ovr_allowed = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule